// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block watches four external request lines that are already timed to the core clock. It turns them into interrupt requests for a processor. Each line first passes through a two-stage synchroniser. A per-channel trigger selector then decides which transitions or levels count as an event. A qualified event latches a pending flag. The flag stays set until the processor takes the request through a valid/ready handshake, or until the line's clear input is pulsed.

The lines do not all offer the same triggers. The two lowest lines accept rising edges, falling edges, a high level or a low level. The two upper lines accept rising edges, falling edges or both edges. The top line also runs through a digital glitch filter, which samples either every cycle, every 16th cycle or every 64th cycle. The filter takes a new level only after two successive samples agree, so the chosen rate sets the shortest pulse the line accepts. The two upper lines also send a one-cycle strobe to a timer, which can count their events.

When more than one enabled request is pending, the lowest line number wins. Its entry address is shown on `irq_vector`. The address is 8 × channel + 3, giving 03h, 0Bh, 13h and 1Bh.

Top module: `xirq_detect`

## Requirements
- R1: On lines 0 to 2, an input change applied before clock edge k raises `irq_valid` after edge k+2, and not after edge k+1.
- R2: For lines 0 and 1, a 3-bit mode code of 1 means falling edge, 2 means rising edge, 4 means high level and 5 means low level. Codes 0, 3, 6 and 7 leave the line inert, and any request it already holds is masked.
- R3: For lines 2 and 3, mode code 1 means falling edge, 2 means rising edge and 3 means both edges. Codes 0 and 4 to 7 leave the line inert and produce neither requests nor timer strobes.
- R4: `irq_vector` shows 03h, 0Bh, 13h or 1Bh for lines 0 to 3.
- R5: When several enabled, well-configured lines are pending, the lowest line number is presented first.
- R6: A request stays on `irq_valid` until `irq_ready` is high at a clock edge. That edge clears the winning line's pending flag. An event arriving on the same edge keeps the flag set. The vector may move to a lower line before acceptance.
- R7: In level mode, the pending flag is set again on every cycle that the level persists. It can only be cleared for good once the level has gone.
- R8: A zero in `irq_en` hides a line's request but keeps its pending flag. A pulse on `pend_clr` drops the flag.
- R9: The line 3 filter samples on every cycle when `flt_sel` is 0, every 16th cycle when it is 1, and every 64th cycle when it is 2 or 3. A level is taken after two equal successive samples. At a rate of 1/1 a 1-cycle pulse is rejected and a 2-cycle pulse is accepted, and the event shows after edge k+4. At 1/16 an 11-cycle pulse is rejected and a 39-cycle pulse is accepted. At 1/64 a 50-cycle pulse is rejected and a 140-cycle pulse is accepted.
- R10: `tmr_evt[0]` for line 2 and `tmr_evt[1]` for line 3 pulse for one cycle on each qualified event, whatever `irq_en` holds. The pulse comes on the same edge that sets the pending flag.
- R11: After reset, no flag is pending, `irq_valid` is low and `tmr_evt` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 4 | Request lines, one per channel |
| trig_mode | input | 12 | Trigger mode code, 3 bits per line; bits [3c+2:3c] belong to line c |
| irq_en | input | 4 | Per-line request enable |
| flt_sel | input | 2 | Line 3 filter rate select |
| pend_clr | input | 4 | Per-line pending clear pulse |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | Processor takes the offered request |
| irq_vector | output | 8 | Entry address of the offered request |
| tmr_evt | output | 2 | Event strobes of lines 2 and 3 for the timer |

## Verification
On lines 0 to 2, a stimulus driven just after a falling edge reaches the pending flag, `irq_valid` and the timer strobe after the third rising edge that follows. On line 3 at the 1/1 rate this becomes the fifth rising edge. At the divided rates the arrival depends on the divider phase, so the bench polls within a bounded window there. For the fixed latencies, the bench samples 2 ns after the edge on which the output is due. It also samples one edge earlier to show that nothing arrives early. A queue holds the expected entry address of each handshake. A monitor samples 1 ns before each rising edge and compares the address whenever `irq_ready` meets `irq_valid`.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_HIGH = 3'd4,
    TRIG_LOW  = 3'd5,
    TRIG_RSV6 = 3'd6,
    TRIG_RSV7 = 3'd7
  } trig_e;

  typedef enum logic [1:0] {
    FDIV_ONE   = 2'd0,
    FDIV_MID   = 2'd1,
    FDIV_SLOW  = 2'd2,
    FDIV_SLOW2 = 2'd3
  } fdiv_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xirq_filter.sv
module xirq_filter
  import xirq_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [1:0] sel,
  output logic       lvl,
  output logic       tick
);
  // Division factors are powers of two; the divider is shared by both rates.
  localparam int CW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam logic [CW-1:0] MID_MASK  = CW'(DIV_MID - 1);
  localparam logic [CW-1:0] SLOW_MASK = CW'(DIV_SLOW - 1);

  logic [CW-1:0] div_cnt;
  logic          samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  always_comb begin
    case (fdiv_e'(sel))
      FDIV_ONE: tick = 1'b1;
      FDIV_MID: tick = ((div_cnt & MID_MASK) == '0);
      default:  tick = ((div_cnt & SLOW_MASK) == '0);
    endcase
  end

  // A level is adopted only when two successive samples agree.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      lvl    <= 1'b0;
    end else if (tick) begin
      samp_q <= raw;
      if (raw == samp_q) lvl <= raw;
    end
  end
endmodule

// File: rtl/xirq_trigger.sv
module xirq_trigger
  import xirq_pkg::*;
#(
  parameter bit HAS_LEVEL = 1'b1,
  parameter bit HAS_BOTH  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic [MODE_W-1:0] mode,
  output logic              evt,
  output logic              mode_ok
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  always_comb begin
    evt     = 1'b0;
    mode_ok = 1'b0;
    case (trig_e'(mode))
      TRIG_FALL: begin mode_ok = 1'b1; evt = lvl_d & ~lvl; end
      TRIG_RISE: begin mode_ok = 1'b1; evt = ~lvl_d & lvl; end
      TRIG_BOTH: if (HAS_BOTH)  begin mode_ok = 1'b1; evt = lvl_d ^ lvl; end
      TRIG_HIGH: if (HAS_LEVEL) begin mode_ok = 1'b1; evt = lvl;          end
      TRIG_LOW:  if (HAS_LEVEL) begin mode_ok = 1'b1; evt = ~lvl;         end
      default: ;
    endcase
  end
endmodule

// File: rtl/xirq_prio.sv
module xirq_prio #(
  parameter int          N        = 4,
  parameter logic [7:0]  VEC_BASE = 8'h03,
  parameter logic [7:0]  VEC_STEP = 8'h08
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] req_en,
  input  logic         ready,
  output logic [N-1:0] pend,
  output logic         valid,
  output logic [7:0]   vector
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  pend_q, live, grant;
  logic [IW-1:0] win;
  logic          take;

  assign live = pend_q & req_en;

  // Walk from the top down so the lowest live line is kept last.
  always_comb begin
    grant = '0;
    win   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        win      = IW'(i);
      end
    end
  end

  assign valid  = |live;
  assign vector = VEC_BASE + 8'(VEC_STEP * win);
  assign take   = valid & ready;

  // A fresh event on the same edge outranks acceptance or clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr & ~(grant & {N{take}})) | set;
  end

  assign pend = pend_q;
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int TMR_FIRST    = 2,
  parameter int FLT_CH       = 3,
  parameter int FLT_DIV_MID  = 16,
  parameter int FLT_DIV_SLOW = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            pin_in,
  input  logic [NCH*MODE_W-1:0]     trig_mode,
  input  logic [NCH-1:0]            irq_en,
  input  logic [1:0]                flt_sel,
  input  logic [NCH-1:0]            pend_clr,
  output logic                      irq_valid,
  input  logic                      irq_ready,
  output logic [7:0]                irq_vector,
  output logic [NCH-TMR_FIRST-1:0]  tmr_evt
);
  localparam int NTMR = NCH - TMR_FIRST;

  logic [NCH-1:0]  sync_q, chan_lvl, evt, mode_ok, pend_q;
  logic [NTMR-1:0] tmr_q;
  logic            flt_tick, flt_lvl;

  xirq_sync #(.W(NCH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == FLT_CH) begin : g_flt
      xirq_filter #(.DIV_MID(FLT_DIV_MID), .DIV_SLOW(FLT_DIV_SLOW)) u_flt (
        .clk(clk), .rst_n(rst_n), .raw(sync_q[c]), .sel(flt_sel),
        .lvl(chan_lvl[c]), .tick(flt_tick)
      );
    end else begin : g_direct
      assign chan_lvl[c] = sync_q[c];
    end

    xirq_trigger #(
      .HAS_LEVEL(c < TMR_FIRST),
      .HAS_BOTH (c >= TMR_FIRST)
    ) u_trig (
      .clk(clk), .rst_n(rst_n), .lvl(chan_lvl[c]),
      .mode(trig_mode[c*MODE_W +: MODE_W]),
      .evt(evt[c]), .mode_ok(mode_ok[c])
    );
  end

  assign flt_lvl = chan_lvl[FLT_CH];

  xirq_prio #(.N(NCH), .VEC_BASE(8'h03), .VEC_STEP(8'h08)) u_prio (
    .clk(clk), .rst_n(rst_n), .set(evt), .clr(pend_clr),
    .req_en(irq_en & mode_ok), .ready(irq_ready),
    .pend(pend_q), .valid(irq_valid), .vector(irq_vector)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= evt[NCH-1:TMR_FIRST];
  end

  assign tmr_evt = tmr_q;
endmodule

// File: rtl/xirq_detect_chk.sv
module xirq_detect_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_valid,
  input logic           irq_ready,
  input logic [7:0]     irq_vector,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] mode_ok,
  input logic [NCH-1:0] evt,
  input logic           flt_lvl,
  input logic           flt_tick
);
  p_vec_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector inside {8'h03, 8'h0B, 8'h13, 8'h1B}));

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vector == 8'h0B) |-> !(pend[0] && en[0] && mode_ok[0]));

  p_grant_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vector == 8'h03) |-> (pend[0] && en[0] && mode_ok[0]));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && irq_vector == 8'h1B && !evt[3]) |=> !pend[3]);

  p_flt_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_lvl != $past(flt_lvl)) |-> $past(flt_tick));
endmodule

bind xirq_detect xirq_detect_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .pend(pend_q), .en(irq_en), .mode_ok(mode_ok),
  .evt(evt), .flt_lvl(flt_lvl), .flt_tick(flt_tick)
);

// File: tb/xirq_detect_tb.sv
module xirq_detect_tb;
  import xirq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin = '0;
  logic [11:0] mode = '0;
  logic [3:0]  en = 4'hF;
  logic [1:0]  fsel = '0;
  logic [3:0]  clr = '0;
  logic        ready = 1'b0;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic [1:0]  tmr_evt;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  xirq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin), .trig_mode(mode), .irq_en(en),
    .flt_sel(fsel), .pend_clr(clr), .irq_valid(irq_valid), .irq_ready(ready),
    .irq_vector(irq_vector), .tmr_evt(tmr_evt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drv_pin(int ch, logic v);
    @(negedge clk); #1; pin[ch] = v;
  endtask

  task automatic set_mode(int ch, trig_e m);
    mode[ch*3 +: 3] = m;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic take(logic [7:0] v);
    exp_q.push_back(v);
    @(negedge clk); #1; ready = 1'b1;
    @(negedge clk); #1; ready = 1'b0;
  endtask

  task automatic pulse_clr(logic [3:0] m);
    @(negedge clk); #1; clr = m;
    @(negedge clk); #1; clr = '0;
  endtask

  task automatic wait_valid(int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      edges(1);
      if (irq_valid) begin ok = 1'b1; break; end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Monitor: compares each handshake against the scoreboard queue (R6, R4).
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk); #3;
      if (irq_valid && ready) begin
        if (exp_q.size() == 0) begin
          vectors++; miscompares++;
          $display("FAIL R6 handshake: got %0h expected none", irq_vector);
        end else begin
          e = exp_q.pop_front();
          check("R6 handshake vector", irq_vector, e);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1'b1;
    edges(1);
    check("R11 valid after reset", irq_valid, 0);
    check("R11 tmr_evt after reset", tmr_evt, 0);

    // Line 0 falling edge: latency R1, rising ignored R2, vector R4.
    set_mode(0, TRIG_FALL);
    drv_pin(0, 1); edges(5);
    check("R2 rise ignored in fall mode", irq_valid, 0);
    drv_pin(0, 0); edges(2);
    check("R1 not before k+2", irq_valid, 0);
    edges(1);
    check("R1 valid at k+2", irq_valid, 1);
    check("R4 vector line0", irq_vector, 8'h03);
    edges(3);
    check("R6 held while not ready", irq_valid, 1);
    take(8'h03); edges(1);
    check("R6 cleared by accept", irq_valid, 0);

    // Line 1 high level re-asserts: R7.
    set_mode(1, TRIG_HIGH);
    drv_pin(1, 1); edges(3);
    check("R7 high level request", irq_valid, 1);
    check("R4 vector line1", irq_vector, 8'h0B);
    take(8'h0B); edges(1);
    check("R7 set again while level holds", irq_valid, 1);
    drv_pin(1, 0); edges(3);
    take(8'h0B); edges(1);
    check("R7 clear once level gone", irq_valid, 0);

    // Line 1 low level, then off mode masks: R2.
    set_mode(1, TRIG_LOW); edges(3);
    check("R2 low level request", irq_vector, 8'h0B);
    check("R2 low level valid", irq_valid, 1);
    set_mode(1, TRIG_OFF); edges(1);
    check("R2 off mode masks request", irq_valid, 0);
    pulse_clr(4'b0010);

    // Line 0 both-edge code is unsupported: R2.
    set_mode(0, TRIG_BOTH);
    drv_pin(0, 1); edges(3); drv_pin(0, 0); edges(3);
    check("R2 code 3 inert on line0", irq_valid, 0);
    set_mode(0, TRIG_OFF);

    // Line 2 level code unsupported, then both edges: R3, R10.
    set_mode(2, TRIG_HIGH);
    drv_pin(2, 1); edges(4);
    check("R3 level code inert on line2", irq_valid, 0);
    check("R3 no strobe when inert", tmr_evt, 0);
    set_mode(2, TRIG_BOTH);
    drv_pin(2, 0); edges(2);
    check("R10 strobe not early", tmr_evt, 0);
    edges(1);
    check("R3 both mode falling", irq_valid, 1);
    check("R4 vector line2", irq_vector, 8'h13);
    check("R10 strobe line2", tmr_evt, 2'b01);
    edges(1);
    check("R10 strobe one cycle", tmr_evt, 0);
    take(8'h13);
    drv_pin(2, 1); edges(3);
    check("R3 both mode rising", irq_vector, 8'h13);
    take(8'h13);
    set_mode(2, TRIG_OFF);

    // Priority: R5.
    set_mode(0, TRIG_RISE); set_mode(1, TRIG_RISE);
    @(negedge clk); #1; pin[1:0] = 2'b11;
    edges(3);
    check("R5 lowest first", irq_vector, 8'h03);
    take(8'h03); edges(1);
    check("R5 next line presented", irq_vector, 8'h0B);
    check("R5 next line valid", irq_valid, 1);
    take(8'h0B); edges(1);
    check("R5 all taken", irq_valid, 0);
    @(negedge clk); #1; pin[1:0] = 2'b00;
    set_mode(1, TRIG_OFF);

    // Enable mask and clear: R8.
    en[0] = 1'b0;
    drv_pin(0, 1); edges(4);
    check("R8 masked request hidden", irq_valid, 0);
    en[0] = 1'b1; edges(1);
    check("R8 pending kept while masked", irq_vector, 8'h03);
    take(8'h03);
    en[0] = 1'b0;
    drv_pin(0, 0); drv_pin(0, 1); edges(4);
    pulse_clr(4'b0001);
    en[0] = 1'b1; edges(1);
    check("R8 clear drops pending", irq_valid, 0);
    drv_pin(0, 0);
    set_mode(0, TRIG_OFF);

    // Line 3 filter at 1/1: R9, R10.
    set_mode(3, TRIG_RISE); fsel = 2'd0;
    drv_pin(3, 1); drv_pin(3, 0); edges(8);
    check("R9 1-cycle pulse rejected", irq_valid, 0);
    drv_pin(3, 1); drv_pin(3, 1); drv_pin(3, 0);
    edges(2);
    check("R9 not before k+4", irq_valid, 0);
    edges(1);
    check("R9 2-cycle pulse accepted", irq_vector, 8'h1B);
    check("R9 valid at k+4", irq_valid, 1);
    check("R10 strobe line3", tmr_evt, 2'b10);
    take(8'h1B);

    // 1/16 rate.
    fsel = 2'd1;
    drv_pin(3, 1); repeat (10) @(negedge clk); drv_pin(3, 0);
    edges(80);
    check("R9 short pulse rejected at 1/16", irq_valid, 0);
    drv_pin(3, 1); repeat (38) @(negedge clk); drv_pin(3, 0);
    wait_valid(100, ok);
    check("R9 long pulse accepted at 1/16", ok, 1);
    check("R9 vector at 1/16", irq_vector, 8'h1B);
    take(8'h1B);

    // 1/64 rate.
    fsel = 2'd2; edges(150);
    drv_pin(3, 1); repeat (49) @(negedge clk); drv_pin(3, 0);
    edges(200);
    check("R9 short pulse rejected at 1/64", irq_valid, 0);
    drv_pin(3, 1); repeat (139) @(negedge clk); drv_pin(3, 0);
    wait_valid(300, ok);
    check("R9 long pulse accepted at 1/64", ok, 1);
    take(8'h1B);
    edges(2);
    check("R6 every expected handshake seen", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule